// File: doc/BRIEF.md
# Branch Resolution and Link Unit

This unit resolves one branch or jump per cycle for a 32-bit pipeline that has a single branch delay slot. Each strobed input carries an opcode class, the values and indices of the two source registers, the instruction's PC, the immediate field and the hint field of a register jump. One cycle later the unit reports four things: whether control is redirected, the address that fetch should use next, whether a return address must be written and to which register, and whether the delay-slot instruction must be squashed.

The unit covers three kinds of transfer. Conditional PC-relative branches compare two registers, or compare one register with zero. Jumps take an absolute immediate address. Register jumps take their target from a register. Each conditional kind also has a "likely" variant, which squashes the delay slot when the branch is not taken. The linking compare-to-zero forms write their return address even when the branch falls through. Encodings the unit does not recognise raise a reserved-instruction flag, and that flag suppresses every side effect. The fetch redirect and the register file write port are outside this unit; it only drives their request signals.

Top module: `branch_resolve_unit`

## Requirements
- R1: The op codes are 1 beq, 2 bne, 3 blez, 4 bgtz, 5 bltz, 6 bgez, 7 bltzal, 8 bgezal, 9 beql, 10 bnel, 11 blezl, 12 bgtzl, 13 bltzl, 14 bgezl, 15 bltzall, 16 bgezall, 17 j, 18 jal, 19 jr and 20 jalr. Codes 0 and 21 to 31 set `resv_exc` and do not redirect.
- R2: When a conditional branch is taken, `target` equals PC + 4 + (sign-extended imm[15:0] shifted left by 2).
- R3: j and jal are always taken, with `target` = {bits 31:28 of PC + 4, imm[25:0], 2'b00}.
- R4: jr and jalr are taken with `target` = rs value when hint is 0 or 16. Any other hint value sets `resv_exc`.
- R5: The conditions are rs == rt, rs != rt, and the signed tests rs <= 0, rs > 0, rs < 0 and rs >= 0.
- R6: A source register whose index is 0 reads as zero, whatever value is on its data input.
- R7: bltzal, bgezal, bltzall, bgezall and jal raise `link_en` with `link_reg` = 31. jalr raises it with `link_reg` = rt index. `link_data` is PC + 8, and the link is requested whether or not the branch is taken.
- R8: A likely branch that is not taken raises `annul`. Whenever `taken` is low and `resv_exc` is low, `target` is PC + 8. A non-likely branch never raises `annul`.
- R9: All outputs are registered. `out_valid` follows `in_valid` by one cycle, and `taken`, `link_en`, `annul` and `resv_exc` are low whenever `out_valid` is low.
- R10: While `resv_exc` is high, `taken`, `link_en` and `annul` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Input strobe |
| op | input | 5 | Branch/jump class code |
| rs_idx | input | 5 | Index of first source register |
| rs_val | input | 32 | Value of first source register |
| rt_idx | input | 5 | Index of second source register, also the link register for jalr |
| rt_val | input | 32 | Value of second source register |
| pc | input | 32 | Address of the branch instruction |
| imm | input | 26 | Immediate field (low 16 bits used for PC-relative) |
| hint | input | 5 | Hint field of register jumps |
| out_valid | output | 1 | Result valid |
| taken | output | 1 | Redirect request |
| target | output | 32 | Next fetch address |
| link_en | output | 1 | Return address write request |
| link_reg | output | 5 | Return address destination |
| link_data | output | 32 | Return address value |
| annul | output | 1 | Squash the delay-slot instruction |
| resv_exc | output | 1 | Reserved-instruction flag |

## Verification
The hardest situation to reach from the ports is a linking likely branch that falls through. That case must request the link and squash the slot in the same cycle while `taken` stays low. The hardest values are the ones at the sign boundary, where zero, -1 and the most negative value separate the six compare-to-zero tests. The random stimulus therefore biases operands toward 0, 1, -1, 0x80000000 and 0x7FFFFFFF. It biases register indices toward 0, so that nonzero data on index-0 registers is tested. It biases hints toward 0 and 16 while still producing reserved hints, and it draws op codes from the full 5-bit range so that reserved codes occur. Directed cases pin down each of these situations once.

// File: rtl/brl_pkg.sv
// Shared types for the branch resolution and link unit.
// Assumes a 5-bit op class code as listed in the unit's requirements.
package brl_pkg;

    typedef enum logic [4:0] {
        OP_BEQ     = 5'd1,  OP_BNE     = 5'd2,  OP_BLEZ    = 5'd3,
        OP_BGTZ    = 5'd4,  OP_BLTZ    = 5'd5,  OP_BGEZ    = 5'd6,
        OP_BLTZAL  = 5'd7,  OP_BGEZAL  = 5'd8,  OP_BEQL    = 5'd9,
        OP_BNEL    = 5'd10, OP_BLEZL   = 5'd11, OP_BGTZL   = 5'd12,
        OP_BLTZL   = 5'd13, OP_BGEZL   = 5'd14, OP_BLTZALL = 5'd15,
        OP_BGEZALL = 5'd16, OP_J       = 5'd17, OP_JAL     = 5'd18,
        OP_JR      = 5'd19, OP_JALR    = 5'd20
    } br_op_e;

    typedef enum logic [2:0] {
        CND_EQ, CND_NE, CND_LEZ, CND_GTZ, CND_LTZ, CND_GEZ, CND_ALWAYS
    } cond_e;

    typedef enum logic [1:0] {
        TGT_PCREL, TGT_JIMM, TGT_JREG
    } tgt_e;

    typedef struct packed {
        logic  legal;
        cond_e cond;
        tgt_e  tsel;
        logic  likely;
        logic  link_fixed;
        logic  link_rt;
        logic  hint_chk;
    } dec_t;

endpackage

// File: rtl/brl_decode.sv
// Op class decoder: maps the 5-bit op code onto condition, target source,
// likely and link attributes. Unknown codes come out with legal = 0.
// Assumes the code assignment of brl_pkg::br_op_e.
module brl_decode
    import brl_pkg::*;
(
    input  logic [4:0] op,
    output dec_t       dec
);

    // Table lookup of attributes per op class
    always_comb begin
        dec = '{legal: 1'b1, cond: CND_ALWAYS, tsel: TGT_PCREL,
                likely: 1'b0, link_fixed: 1'b0, link_rt: 1'b0, hint_chk: 1'b0};
        case (op)
            OP_BEQ:     dec.cond = CND_EQ;
            OP_BNE:     dec.cond = CND_NE;
            OP_BLEZ:    dec.cond = CND_LEZ;
            OP_BGTZ:    dec.cond = CND_GTZ;
            OP_BLTZ:    dec.cond = CND_LTZ;
            OP_BGEZ:    dec.cond = CND_GEZ;
            OP_BLTZAL:  begin dec.cond = CND_LTZ; dec.link_fixed = 1'b1; end
            OP_BGEZAL:  begin dec.cond = CND_GEZ; dec.link_fixed = 1'b1; end
            OP_BEQL:    begin dec.cond = CND_EQ;  dec.likely = 1'b1; end
            OP_BNEL:    begin dec.cond = CND_NE;  dec.likely = 1'b1; end
            OP_BLEZL:   begin dec.cond = CND_LEZ; dec.likely = 1'b1; end
            OP_BGTZL:   begin dec.cond = CND_GTZ; dec.likely = 1'b1; end
            OP_BLTZL:   begin dec.cond = CND_LTZ; dec.likely = 1'b1; end
            OP_BGEZL:   begin dec.cond = CND_GEZ; dec.likely = 1'b1; end
            OP_BLTZALL: begin dec.cond = CND_LTZ; dec.likely = 1'b1; dec.link_fixed = 1'b1; end
            OP_BGEZALL: begin dec.cond = CND_GEZ; dec.likely = 1'b1; dec.link_fixed = 1'b1; end
            OP_J:       dec.tsel = TGT_JIMM;
            OP_JAL:     begin dec.tsel = TGT_JIMM; dec.link_fixed = 1'b1; end
            OP_JR:      begin dec.tsel = TGT_JREG; dec.hint_chk = 1'b1; end
            OP_JALR:    begin dec.tsel = TGT_JREG; dec.hint_chk = 1'b1; dec.link_rt = 1'b1; end
            default:    dec.legal = 1'b0;
        endcase
    end

endmodule

// File: rtl/brl_cond.sv
// Condition evaluator: equality between two operands and signed tests of
// the first operand against zero. Assumes two's complement operands.
module brl_cond
    import brl_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  cond_e           cond,
    input  logic [XLEN-1:0] a,
    input  logic [XLEN-1:0] b,
    output logic            hit
);

    logic is_zero;
    logic is_neg;

    // Sign and zero flags of the first operand
    always_comb begin
        is_zero = (a == '0);
        is_neg  = a[XLEN-1];
    end

    // Condition select
    always_comb begin
        case (cond)
            CND_EQ:  hit = (a == b);
            CND_NE:  hit = (a != b);
            CND_LEZ: hit = is_neg | is_zero;
            CND_GTZ: hit = ~is_neg & ~is_zero;
            CND_LTZ: hit = is_neg;
            CND_GEZ: hit = ~is_neg;
            default: hit = 1'b1;
        endcase
    end

endmodule

// File: rtl/brl_target.sv
// Target address generator: PC-relative, absolute-region and register forms.
// Assumes IMMW + 2 < XLEN and OFFW <= IMMW.
module brl_target
    import brl_pkg::*;
#(
    parameter int XLEN = 32,
    parameter int IMMW = 26,
    parameter int OFFW = 16
) (
    input  tgt_e            tsel,
    input  logic [XLEN-1:0] pc,
    input  logic [IMMW-1:0] imm,
    input  logic [XLEN-1:0] rs,
    output logic [XLEN-1:0] btgt
);

    localparam int SEXT = XLEN - OFFW - 2;
    localparam int HI   = XLEN - IMMW - 2;

    logic [XLEN-1:0] pc4;
    logic [XLEN-1:0] off;

    // Sequential PC and scaled signed offset
    always_comb begin
        pc4 = pc + XLEN'(4);
        off = {{SEXT{imm[OFFW-1]}}, imm[OFFW-1:0], 2'b00};
    end

    // Target source select
    always_comb begin
        case (tsel)
            TGT_JIMM: btgt = {pc4[XLEN-1 -: HI], imm, 2'b00};
            TGT_JREG: btgt = rs;
            default:  btgt = pc4 + off;
        endcase
    end

endmodule

// File: rtl/branch_resolve_unit.sv
// Branch resolution and link unit. Decodes the op class, gates index-0
// operands to zero, evaluates the condition, forms the target, and
// registers taken/target/link/annul/exception one cycle after in_valid.
// Assumes one delay slot: fall-through address is PC + 8.
module branch_resolve_unit
    import brl_pkg::*;
#(
    parameter int XLEN     = 32,
    parameter int RIDX     = 5,
    parameter int IMMW     = 26,
    parameter int OFFW     = 16,
    parameter int HINTW    = 5,
    parameter int LINK_REG = 31,
    parameter bit ZERO_REG = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [4:0]       op,
    input  logic [RIDX-1:0]  rs_idx,
    input  logic [XLEN-1:0]  rs_val,
    input  logic [RIDX-1:0]  rt_idx,
    input  logic [XLEN-1:0]  rt_val,
    input  logic [XLEN-1:0]  pc,
    input  logic [IMMW-1:0]  imm,
    input  logic [HINTW-1:0] hint,
    output logic             out_valid,
    output logic             taken,
    output logic [XLEN-1:0]  target,
    output logic             link_en,
    output logic [RIDX-1:0]  link_reg,
    output logic [XLEN-1:0]  link_data,
    output logic             annul,
    output logic             resv_exc
);

    localparam logic [HINTW-1:0] HINT_PLAIN = '0;
    localparam logic [HINTW-1:0] HINT_HB    = HINTW'(16);

    dec_t            dec;
    logic [XLEN-1:0] rs_eff;
    logic [XLEN-1:0] rt_eff;
    logic            hit;
    logic [XLEN-1:0] btgt;
    logic            hint_ok;
    logic            exc_c;
    logic            taken_c;
    logic            annul_c;
    logic            link_c;
    logic [XLEN-1:0] fall_c;

    brl_decode u_dec (
        .op  (op),
        .dec (dec)
    );

    generate
        if (ZERO_REG) begin : g_zero
            // Register index 0 is hardwired to zero
            always_comb begin
                rs_eff = (rs_idx == '0) ? '0 : rs_val;
                rt_eff = (rt_idx == '0) ? '0 : rt_val;
            end
        end else begin : g_pass
            // Operands used as supplied
            always_comb begin
                rs_eff = rs_val;
                rt_eff = rt_val;
            end
        end
    endgenerate

    brl_cond #(.XLEN(XLEN)) u_cond (
        .cond (dec.cond),
        .a    (rs_eff),
        .b    (rt_eff),
        .hit  (hit)
    );

    brl_target #(.XLEN(XLEN), .IMMW(IMMW), .OFFW(OFFW)) u_tgt (
        .tsel (dec.tsel),
        .pc   (pc),
        .imm  (imm),
        .rs   (rs_eff),
        .btgt (btgt)
    );

    // Legality, side-effect gating and next-fetch selection
    always_comb begin
        hint_ok = ~dec.hint_chk | (hint == HINT_PLAIN) | (hint == HINT_HB);
        exc_c   = ~dec.legal | ~hint_ok;
        taken_c = ~exc_c & hit;
        annul_c = ~exc_c & dec.likely & ~hit;
        link_c  = ~exc_c & (dec.link_fixed | dec.link_rt);
        fall_c  = pc + XLEN'(8);
    end

    // Output register stage
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            taken     <= 1'b0;
            link_en   <= 1'b0;
            annul     <= 1'b0;
            resv_exc  <= 1'b0;
            target    <= '0;
            link_reg  <= '0;
            link_data <= '0;
        end else begin
            out_valid <= in_valid;
            taken     <= in_valid & taken_c;
            link_en   <= in_valid & link_c;
            annul     <= in_valid & annul_c;
            resv_exc  <= in_valid & exc_c;
            if (in_valid) begin
                target    <= taken_c ? btgt : fall_c;
                link_reg  <= dec.link_rt ? rt_idx : RIDX'(LINK_REG);
                link_data <= fall_c;
            end
        end
    end

endmodule

// File: rtl/brl_checker.sv
// Property checker for branch_resolve_unit, attached by bind.
module brl_checker #(
    parameter int XLEN = 32,
    parameter int RIDX = 5
) (
    input logic            clk,
    input logic            rst_n,
    input logic            in_valid,
    input logic [XLEN-1:0] pc,
    input logic            out_valid,
    input logic            taken,
    input logic [XLEN-1:0] target,
    input logic            link_en,
    input logic [XLEN-1:0] link_data,
    input logic            annul,
    input logic            resv_exc
);

    AST_EXC_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        resv_exc |-> (!taken && !link_en && !annul)); // R10

    AST_ANNUL_ONLY_FALLTHRU: assert property (@(posedge clk) disable iff (!rst_n)
        annul |-> !taken); // R8

    AST_FALLTHRU_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !taken && !resv_exc) |-> (target == link_data)); // R8

    AST_VALID_DELAY: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid); // R9

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> (!taken && !link_en && !annul && !resv_exc)); // R9

    AST_LINK_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> (link_data == $past(pc) + XLEN'(8))); // R7

endmodule

bind branch_resolve_unit brl_checker #(.XLEN(XLEN), .RIDX(RIDX)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .pc        (pc),
    .out_valid (out_valid),
    .taken     (taken),
    .target    (target),
    .link_en   (link_en),
    .link_data (link_data),
    .annul     (annul),
    .resv_exc  (resv_exc)
);

// File: tb/sim_branch_resolve_unit.sv
// Bench: directed corner cases plus seeded random stimulus, checked against
// a reference model written from the requirements.
module sim_branch_resolve_unit;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [4:0]  op = '0;
    logic [4:0]  rs_idx = '0;
    logic [31:0] rs_val = '0;
    logic [4:0]  rt_idx = '0;
    logic [31:0] rt_val = '0;
    logic [31:0] pc = '0;
    logic [25:0] imm = '0;
    logic [4:0]  hint = '0;
    logic        out_valid, taken, link_en, annul, resv_exc;
    logic [31:0] target, link_data;
    logic [4:0]  link_reg;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    branch_resolve_unit u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op(op),
        .rs_idx(rs_idx), .rs_val(rs_val), .rt_idx(rt_idx), .rt_val(rt_val),
        .pc(pc), .imm(imm), .hint(hint), .out_valid(out_valid),
        .taken(taken), .target(target), .link_en(link_en),
        .link_reg(link_reg), .link_data(link_data), .annul(annul),
        .resv_exc(resv_exc)
    );

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h (op=%0d)", req, what, act, exp, op);
        end
    endtask

    // Reference model from the requirements
    typedef struct {
        bit          tk, an, ln, ex;
        logic [4:0]  lr;
        logic [31:0] tg, ld;
    } exp_t;

    function automatic exp_t model(input logic [4:0] o, input logic [4:0] si,
        input logic [31:0] sv, input logic [4:0] ti, input logic [31:0] tv,
        input logic [31:0] p, input logic [25:0] im, input logic [4:0] h);
        exp_t e;
        logic [31:0] a, b, rel, fall, p4;
        bit hit, lik, l31, lrt, legal, hck;
        a = (si == 0) ? 32'd0 : sv;     // R6
        b = (ti == 0) ? 32'd0 : tv;
        p4 = p + 32'd4;
        fall = p + 32'd8;
        rel = p4 + {{14{im[15]}}, im[15:0], 2'b00};
        legal = 1; lik = 0; l31 = 0; lrt = 0; hck = 0; hit = 0;
        e.tg = fall;
        case (o)
            1, 9:   hit = (a == b);
            2, 10:  hit = (a != b);
            3, 11:  hit = ($signed(a) <= 0);
            4, 12:  hit = ($signed(a) > 0);
            5, 13, 7, 15: hit = ($signed(a) < 0);
            6, 14, 8, 16: hit = ($signed(a) >= 0);
            17, 18: hit = 1;
            19, 20: begin hit = 1; hck = 1; end
            default: legal = 0;
        endcase
        if (o >= 9 && o <= 16) lik = 1;
        if (o == 7 || o == 8 || o == 15 || o == 16 || o == 18) l31 = 1;
        if (o == 20) lrt = 1;
        e.ex = !legal || (hck && h != 0 && h != 16);
        e.tk = !e.ex && hit;
        e.an = !e.ex && lik && !hit;
        e.ln = !e.ex && (l31 || lrt);
        e.lr = lrt ? ti : 5'd31;
        e.ld = fall;
        if (e.tk) begin
            if (o == 17 || o == 18) e.tg = {p4[31:28], im, 2'b00};
            else if (o == 19 || o == 20) e.tg = a;
            else e.tg = rel;
        end
        return e;
    endfunction

    task automatic run(input string req, input logic [4:0] o, input logic [4:0] si,
        input logic [31:0] sv, input logic [4:0] ti, input logic [31:0] tv,
        input logic [31:0] p, input logic [25:0] im, input logic [4:0] h);
        exp_t e;
        e = model(o, si, sv, ti, tv, p, im, h);
        @(negedge clk);
        op = o; rs_idx = si; rs_val = sv; rt_idx = ti; rt_val = tv;
        pc = p; imm = im; hint = h; in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        chk({req, " R9"}, "out_valid", {31'd0, out_valid}, 32'd1);
        chk({req, " R10"}, "resv_exc", {31'd0, resv_exc}, {31'd0, e.ex});
        chk({req, " R2"}, "taken", {31'd0, taken}, {31'd0, e.tk});
        chk({req, " R8"}, "annul", {31'd0, annul}, {31'd0, e.an});
        chk({req, " R7"}, "link_en", {31'd0, link_en}, {31'd0, e.ln});
        if (!e.ex) chk({req, " R3"}, "target", target, e.tg);
        if (e.ln) begin
            chk({req, " R7"}, "link_reg", {27'd0, link_reg}, {27'd0, e.lr});
            chk({req, " R7"}, "link_data", link_data, e.ld);
        end
    endtask

    function automatic logic [31:0] pick_val();
        case ($urandom % 7)
            0: return 32'd0;
            1: return 32'd1;
            2: return 32'hFFFF_FFFF;
            3: return 32'h8000_0000;
            4: return 32'h7FFF_FFFF;
            default: return $urandom;
        endcase
    endfunction

    // Watchdog
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        // reset state, R9
        chk("R9", "reset out_valid", {31'd0, out_valid}, 32'd0);
        chk("R9", "reset taken", {31'd0, taken}, 32'd0);
        chk("R9", "reset resv_exc", {31'd0, resv_exc}, 32'd0);
        rst_n = 1'b1;
        // R1 reserved codes
        run("R1 code0", 5'd0, 5'd1, 32'd5, 5'd1, 32'd5, 32'h100, 26'd4, 5'd0);
        run("R1 code21", 5'd21, 5'd1, 32'd5, 5'd1, 32'd5, 32'h100, 26'd4, 5'd0);
        run("R1 code31", 5'd31, 5'd2, 32'd0, 5'd3, 32'd0, 32'h100, 26'd4, 5'd0);
        // R2 backward and forward offsets
        run("R2 beq back", 5'd1, 5'd3, 32'd7, 5'd4, 32'd7, 32'h0000_1000, 26'h000FFFF, 5'd0);
        run("R2 bne fwd", 5'd2, 5'd3, 32'd7, 5'd4, 32'd8, 32'h0000_1000, 26'h0007FFF, 5'd0);
        // R3 region crossing on PC + 4
        run("R3 j region", 5'd17, 5'd0, 32'd0, 5'd0, 32'd0, 32'h1FFF_FFFC, 26'h3FF_FFFF, 5'd0);
        run("R3 jal", 5'd18, 5'd0, 32'd0, 5'd0, 32'd0, 32'hA000_0040, 26'h0123456, 5'd0);
        // R4 hints
        run("R4 jr hint0", 5'd19, 5'd9, 32'hDEAD_BEEC, 5'd0, 32'd0, 32'h200, 26'd0, 5'd0);
        run("R4 jalr hint16", 5'd20, 5'd9, 32'h0040_0000, 5'd12, 32'd0, 32'h200, 26'd0, 5'd16);
        run("R4 jalr hint1 R10", 5'd20, 5'd9, 32'h0040_0000, 5'd12, 32'd0, 32'h200, 26'd0, 5'd1);
        // R5 sign boundary
        run("R5 blez zero", 5'd3, 5'd5, 32'd0, 5'd0, 32'd0, 32'h300, 26'd8, 5'd0);
        run("R5 bgtz min", 5'd4, 5'd5, 32'h8000_0000, 5'd0, 32'd0, 32'h300, 26'd8, 5'd0);
        run("R5 bltz m1", 5'd5, 5'd5, 32'hFFFF_FFFF, 5'd0, 32'd0, 32'h300, 26'd8, 5'd0);
        // R6 index 0 with nonzero data
        run("R6 beq r0", 5'd1, 5'd0, 32'h1234, 5'd0, 32'h5678, 32'h400, 26'd2, 5'd0);
        run("R6 bnel r0", 5'd10, 5'd0, 32'h1234, 5'd0, 32'h5678, 32'h400, 26'd2, 5'd0);
        // R7 link on not-taken, R8 annul
        run("R7 bltzall nt", 5'd15, 5'd6, 32'd3, 5'd0, 32'd0, 32'h500, 26'd2, 5'd0);
        run("R7 bgezal nt", 5'd8, 5'd6, 32'hFFFF_FFF0, 5'd0, 32'd0, 32'h500, 26'd2, 5'd0);
        run("R8 bgtz nt", 5'd4, 5'd6, 32'd0, 5'd0, 32'd0, 32'h500, 26'd2, 5'd0);
        // R9 idle cycle after a gap
        @(negedge clk);
        chk("R9", "idle out_valid", {31'd0, out_valid}, 32'd0);
        chk("R9", "idle taken", {31'd0, taken}, 32'd0);
        chk("R9", "idle link_en", {31'd0, link_en}, 32'd0);
        // random
        for (int i = 0; i < 600; i++) begin
            logic [4:0] o, si, ti, h;
            o  = ($urandom % 4 == 0) ? 5'($urandom) : 5'(1 + $urandom % 20);
            si = ($urandom % 4 == 0) ? 5'd0 : 5'($urandom);
            ti = ($urandom % 4 == 0) ? 5'd0 : 5'($urandom);
            h  = ($urandom % 3 == 0) ? 5'($urandom) : (($urandom % 2) ? 5'd16 : 5'd0);
            run("R5 rand", o, si, pick_val(), ti, pick_val(), {$urandom} & ~32'd3,
                26'($urandom), h);
        end
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule